// File: doc/BRIEF.md
# Damped Wave-Equation Mesh Node

This block is a single processing element of a finite-difference solver for the two-dimensional wave equation. It keeps the displacement of one mesh point at the present step and at the step before it. On each strobe it combines these with the four neighbouring displacements, a propagation coefficient and a damping coefficient to form the displacement for the next step. All displacements are signed fixed point with 17 fractional bits in 18 bits, so the range is [-1, 1 - 2^-17].

A solver instantiates one node per mesh point and strobes them all once per audio sample. Before a strike, the initial state is written through the load port. A typical strike loads the same value, about one eighth of full scale, into both the present and the previous displacement. The node can also be tested on its own by tying all four neighbours to zero. It then behaves as a discrete harmonic oscillator.

Internally a small state machine has two named states. ST_IDLE means no fresh result is present. ST_READY means the output was produced by an update in the previous cycle. The named transitions are:
- GO_STEP: any state to ST_READY on a strobe without a load.
- GO_REST: ST_READY to ST_IDLE when there is no strobe.
- GO_LOAD: any state to ST_IDLE when a load is applied.

Top module: `wave_node_pe`

## Requirements
- R1: While reset (`rst_ni` low) is applied, and after it is released, the present and previous displacements read 0 and `valid_o` is 0 until the first strobe.
- R2: A cycle with `load_i` high writes `load_cur_i` into the present displacement and `load_prev_i` into the previous one. Load takes priority over `step_i` in the same cycle, and `valid_o` is 0 in the following cycle.
- R3: A strobe computes the next displacement using two's-complement values with 17 fractional bits and `>>>` as an arithmetic right shift (floor), where d = 2^17 - eta:
  - L = N + S + E + W - 4u
  - m1 = (rho*L) >>> 17
  - m2 = (d*p) >>> 17
  - s = m1 + 2u - m2
  - next = (d*s) >>> 17, saturated to the 18-bit range

  The coefficients use the same format, with rho in [0, 0.5] and eta in [0, 0.5).
- R4: On a strobe the previous displacement takes the old present value, and the present displacement takes the new value.
- R5: `valid_o` is 1 in exactly the cycle after each strobe, and `u_cur_o` then holds the new result.
- R6: Without a strobe or load, the stored state does not change, even if neighbours or coefficients change.
- R7: A result outside the 18-bit range is clamped to 131071 or -131072 and never wraps.
- R8: A lone node with zero neighbours, rho = 1/16 and eta = 0, loaded with u = p = 16384, oscillates. Its sign changes at least 10 times in 100 steps and its magnitude stays below 32768.
- R9: With rho = 0.5, eta = 0 and zero neighbours, loaded with u = p = A, the outputs follow -A, -A, A, A, repeating, which is a square-like wave.
- R10: With eta > 0 the oscillation of a lone node decays. The peak magnitude over steps 500 to 599 is below that over steps 0 to 99.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| step_i | input | 1 | Update strobe |
| load_i | input | 1 | Write initial conditions |
| load_cur_i | input | 18 | Initial present displacement |
| load_prev_i | input | 18 | Initial previous displacement |
| nbr_n_i | input | 18 | North neighbour displacement |
| nbr_s_i | input | 18 | South neighbour displacement |
| nbr_e_i | input | 18 | East neighbour displacement |
| nbr_w_i | input | 18 | West neighbour displacement |
| rho_i | input | 18 | Propagation coefficient |
| eta_i | input | 18 | Damping coefficient |
| u_cur_o | output | 18 | Present displacement |
| u_prev_o | output | 18 | Previous displacement |
| valid_o | output | 1 | Fresh result flag |

## Verification
On every cycle, the embedded properties check the following: state is held while there is no strobe, the state shifts on a strobe, a load is captured, and the valid flag follows the strobe by exactly one cycle. The arithmetic itself can only be shown by the directed scenarios, which compare results bit for bit against a model of the update. These scenarios cover clamping at both rails, harmonic motion at rho = 1/16, the square-like pattern at rho = 0.5, and the decay under damping.

// File: rtl/wave_pkg.sv
package wave_pkg;
    localparam int unsigned DEF_DW    = 18;
    localparam int unsigned DEF_FRAC  = 17;
    localparam int unsigned DEF_GUARD = 4;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_READY = 1'b1
    } node_state_e;
endpackage

// File: rtl/wave_laplace.sv
module wave_laplace #(
    parameter int unsigned DW = 18,
    parameter int unsigned WW = 22
) (
    input  logic signed [DW-1:0] n_i,
    input  logic signed [DW-1:0] s_i,
    input  logic signed [DW-1:0] e_i,
    input  logic signed [DW-1:0] w_i,
    input  logic signed [DW-1:0] u_i,
    output logic signed [WW-1:0] lap_o
);
    localparam int unsigned EXT = WW - DW;

    logic signed [WW-1:0] n_x, s_x, e_x, w_x, u_x;

    assign n_x = {{EXT{n_i[DW-1]}}, n_i};
    assign s_x = {{EXT{s_i[DW-1]}}, s_i};
    assign e_x = {{EXT{e_i[DW-1]}}, e_i};
    assign w_x = {{EXT{w_i[DW-1]}}, w_i};
    assign u_x = {{EXT{u_i[DW-1]}}, u_i};

    // neighbour sum minus four times the centre
    assign lap_o = (n_x + s_x) + (e_x + w_x) - (u_x <<< 2);
endmodule

// File: rtl/wave_fix_mul.sv
module wave_fix_mul #(
    parameter int unsigned WW   = 22,
    parameter int unsigned FRAC = 17
) (
    input  logic signed [WW-1:0] a_i,
    input  logic signed [WW-1:0] b_i,
    output logic signed [WW-1:0] p_o
);
    localparam int unsigned PW = 2 * WW;

    logic signed [PW-1:0] prod;

    assign prod = a_i * b_i;
    // keeping the bits above the fraction floors the scaled product
    assign p_o  = prod[FRAC+WW-1:FRAC];
endmodule

// File: rtl/wave_sat.sv
module wave_sat #(
    parameter int unsigned DW = 18,
    parameter int unsigned WW = 22
) (
    input  logic signed [WW-1:0] x_i,
    output logic signed [DW-1:0] y_o
);
    localparam logic signed [WW-1:0] HI = WW'((1 << (DW - 1)) - 1);
    localparam logic signed [WW-1:0] LO = -WW'(1 << (DW - 1));

    always_comb begin
        if (x_i > HI) begin
            y_o = HI[DW-1:0];
        end else if (x_i < LO) begin
            y_o = LO[DW-1:0];
        end else begin
            y_o = x_i[DW-1:0];
        end
    end
endmodule

// File: rtl/wave_node_pe.sv
module wave_node_pe
    import wave_pkg::*;
#(
    parameter int unsigned DW    = DEF_DW,
    parameter int unsigned FRAC  = DEF_FRAC,
    parameter int unsigned GUARD = DEF_GUARD
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 step_i,
    input  logic                 load_i,
    input  logic signed [DW-1:0] load_cur_i,
    input  logic signed [DW-1:0] load_prev_i,
    input  logic signed [DW-1:0] nbr_n_i,
    input  logic signed [DW-1:0] nbr_s_i,
    input  logic signed [DW-1:0] nbr_e_i,
    input  logic signed [DW-1:0] nbr_w_i,
    input  logic signed [DW-1:0] rho_i,
    input  logic signed [DW-1:0] eta_i,
    output logic signed [DW-1:0] u_cur_o,
    output logic signed [DW-1:0] u_prev_o,
    output logic                 valid_o
);
    localparam int unsigned WW  = DW + GUARD;
    localparam int unsigned EXT = WW - DW;
    localparam logic signed [WW-1:0] ONE_W = WW'(1 << FRAC);

    node_state_e state_q, state_d;

    logic signed [DW-1:0] cur_q, prev_q, next_sat;
    logic signed [WW-1:0] lap_w, rho_w, damp_w, prev_w, cur_w;
    logic signed [WW-1:0] m1_w, m2_w, sum_w, next_w;

    // ---------------- arithmetic datapath ----------------
    assign rho_w  = {{EXT{rho_i[DW-1]}}, rho_i};
    assign damp_w = ONE_W - {{EXT{eta_i[DW-1]}}, eta_i};
    assign prev_w = {{EXT{prev_q[DW-1]}}, prev_q};
    assign cur_w  = {{EXT{cur_q[DW-1]}}, cur_q};

    wave_laplace #(.DW(DW), .WW(WW)) u_lap (
        .n_i   (nbr_n_i),
        .s_i   (nbr_s_i),
        .e_i   (nbr_e_i),
        .w_i   (nbr_w_i),
        .u_i   (cur_q),
        .lap_o (lap_w)
    );

    wave_fix_mul #(.WW(WW), .FRAC(FRAC)) u_mul_rho (
        .a_i (rho_w),
        .b_i (lap_w),
        .p_o (m1_w)
    );

    wave_fix_mul #(.WW(WW), .FRAC(FRAC)) u_mul_prev (
        .a_i (damp_w),
        .b_i (prev_w),
        .p_o (m2_w)
    );

    assign sum_w = m1_w + (cur_w <<< 1) - m2_w;

    wave_fix_mul #(.WW(WW), .FRAC(FRAC)) u_mul_out (
        .a_i (damp_w),
        .b_i (sum_w),
        .p_o (next_w)
    );

    wave_sat #(.DW(DW), .WW(WW)) u_sat (
        .x_i (next_w),
        .y_o (next_sat)
    );

    // ---------------- state machine ----------------
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (step_i && !load_i) state_d = ST_READY;   // GO_STEP
            end
            ST_READY: begin
                if (load_i)       state_d = ST_IDLE;         // GO_LOAD
                else if (!step_i) state_d = ST_IDLE;         // GO_REST
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // output process
    always_comb begin
        valid_o = (state_q == ST_READY);
    end

    // ---------------- node state ----------------
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cur_q  <= '0;
            prev_q <= '0;
        end else if (load_i) begin
            cur_q  <= load_cur_i;
            prev_q <= load_prev_i;
        end else if (step_i) begin
            cur_q  <= next_sat;
            prev_q <= cur_q;
        end
    end

    assign u_cur_o  = cur_q;
    assign u_prev_o = prev_q;

    // ---------------- assertions ----------------
    // R6
    hold_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!step_i && !load_i) |=> ($stable(u_cur_o) && $stable(u_prev_o)));

    // R4
    shift_prev_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (step_i && !load_i) |=> (u_prev_o == $past(u_cur_o)));

    // R2
    load_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_i |=> (u_cur_o == $past(load_cur_i) && u_prev_o == $past(load_prev_i) && !valid_o));

    // R5
    valid_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (step_i && !load_i) |=> valid_o);

    // R5
    valid_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !step_i |=> !valid_o);
endmodule

// File: tb/test_wave_node_pe.sv
module test_wave_node_pe;
    localparam int DW = 18;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic step = 1'b0, load = 1'b0;
    logic signed [DW-1:0] ld_cur = '0, ld_prev = '0;
    logic signed [DW-1:0] nn = '0, ns = '0, ne = '0, nw = '0;
    logic signed [DW-1:0] rho = '0, eta = '0;
    logic signed [DW-1:0] u_cur, u_prev;
    logic valid;

    int n_checks = 0;
    int n_fail = 0;
    longint m_cur = 0, m_prev = 0;

    always #5 clk = ~clk;

    wave_node_pe i_wave_node_pe (
        .clk_i (clk), .rst_ni (rst_n), .step_i (step), .load_i (load),
        .load_cur_i (ld_cur), .load_prev_i (ld_prev),
        .nbr_n_i (nn), .nbr_s_i (ns), .nbr_e_i (ne), .nbr_w_i (nw),
        .rho_i (rho), .eta_i (eta),
        .u_cur_o (u_cur), .u_prev_o (u_prev), .valid_o (valid)
    );

    task automatic check(input string req, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint model(input longint n, s, e, w, u, p, r, et);
        longint lap, d, m1, m2, sm, nx;
        lap = n + s + e + w - 4 * u;
        d   = 131072 - et;
        m1  = (r * lap) >>> 17;
        m2  = (d * p) >>> 17;
        sm  = m1 + 2 * u - m2;
        nx  = (d * sm) >>> 17;
        if (nx > 131071) nx = 131071;
        if (nx < -131072) nx = -131072;
        return nx;
    endfunction

    task automatic do_load(input longint c, input longint p);
        @(negedge clk);
        load = 1'b1; ld_cur = DW'(c); ld_prev = DW'(p);
        @(negedge clk);
        load = 1'b0;
        m_cur = c; m_prev = p;
    endtask

    task automatic do_step(input string req);
        longint nx;
        nx = model(nn, ns, ne, nw, m_cur, m_prev, rho, eta);
        @(negedge clk);
        step = 1'b1;
        @(negedge clk);
        step = 1'b0;
        m_prev = m_cur; m_cur = nx;
        check(req, u_cur, m_cur);
    endtask

    task automatic t_reset();
        check("R1 cur", u_cur, 0);
        check("R1 prev", u_prev, 0);
        check("R1 valid", valid, 0);
    endtask

    task automatic t_load();
        do_load(1234, -567);
        check("R2 cur", u_cur, 1234);
        check("R2 prev", u_prev, -567);
        check("R2 valid", valid, 0);
        // load wins over a simultaneous strobe
        @(negedge clk);
        load = 1'b1; step = 1'b1; ld_cur = 18'sd777; ld_prev = 18'sd888;
        @(negedge clk);
        load = 1'b0; step = 1'b0;
        m_cur = 777; m_prev = 888;
        check("R2 prio cur", u_cur, 777);
        check("R2 prio prev", u_prev, 888);
        check("R2 prio valid", valid, 0);
    endtask

    task automatic t_update();
        rho = 18'sd12000; eta = 18'sd300;
        nn = 18'sd20000; ns = -18'sd5000; ne = 18'sd777; nw = -18'sd40000;
        do_load(9000, -3000);
        do_step("R3 mixed");
        check("R4 shift", u_prev, 9000);
        check("R5 valid after strobe", valid, 1);
        nn = -18'sd60000; ns = 18'sd1; ne = 18'sd33333; nw = 18'sd100000;
        do_step("R3 second");
        check("R4 shift2", u_prev, m_prev);
        @(negedge clk);
        check("R5 valid one cycle", valid, 0);
    endtask

    task automatic t_hold();
        longint c, p;
        c = m_cur; p = m_prev;
        nn = 18'sd50000; rho = 18'sd40000; eta = 18'sd1000;
        repeat (3) @(negedge clk);
        check("R6 cur", u_cur, c);
        check("R6 prev", u_prev, p);
        check("R6 valid", valid, 0);
    endtask

    task automatic t_saturate();
        rho = 18'sd65535; eta = 18'sd0;
        nn = 18'sd131071; ns = 18'sd131071; ne = 18'sd131071; nw = 18'sd131071;
        do_load(-131072, 0);
        do_step("R7 high");
        check("R7 high rail", u_cur, 131071);
        nn = -18'sd131072; ns = -18'sd131072; ne = -18'sd131072; nw = -18'sd131072;
        do_load(131071, 0);
        do_step("R7 low");
        check("R7 low rail", u_cur, -131072);
    endtask

    task automatic t_harmonic();
        int flips = 0;
        longint pk = 0, last;
        nn = '0; ns = '0; ne = '0; nw = '0;
        rho = 18'sd8192; eta = 18'sd0;
        do_load(16384, 16384);
        last = 16384;
        for (int i = 0; i < 100; i++) begin
            do_step("R8 model");
            if ((m_cur < 0) != (last < 0)) flips++;
            last = m_cur;
            if (m_cur > pk) pk = m_cur;
            if (-m_cur > pk) pk = -m_cur;
        end
        check("R8 sign changes >= 10", (flips >= 10) ? 1 : 0, 1);
        check("R8 bounded", (pk < 32768) ? 1 : 0, 1);
    endtask

    task automatic t_square();
        longint pat [4] = '{-16384, -16384, 16384, 16384};
        nn = '0; ns = '0; ne = '0; nw = '0;
        rho = 18'sd65536; eta = 18'sd0;
        do_load(16384, 16384);
        for (int i = 0; i < 8; i++) begin
            do_step("R9 model");
            check("R9 pattern", u_cur, pat[i % 4]);
        end
    endtask

    task automatic t_damp();
        longint early = 0, late = 0, a;
        nn = '0; ns = '0; ne = '0; nw = '0;
        rho = 18'sd8192; eta = 18'sd131;
        do_load(16384, 16384);
        for (int i = 0; i < 600; i++) begin
            do_step("R10 model");
            a = (m_cur < 0) ? -m_cur : m_cur;
            if (i < 100 && a > early) early = a;
            if (i >= 500 && a > late) late = a;
        end
        check("R10 decay", (late < early) ? 1 : 0, 1);
    endtask

    initial begin
        #1;
        t_reset();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_load();
        t_update();
        t_hold();
        t_saturate();
        t_harmonic();
        t_square();
        t_damp();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #2000000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule